// File: doc/BRIEF.md
# Circular Trace Capture Buffer

This block is a trace sink. It takes a stream of 32-bit trace words and writes them into an on-chip RAM used as a ring. While capture is on, each accepted word goes to the slot at the write pointer and the pointer then moves on by one. When the pointer wraps past the top of the RAM, a sticky full flag records that the oldest surviving word now sits at the write pointer. A small register bus lets software do the following:
- turn capture on and off;
- move both pointers;
- clear or fill the RAM through an auto-incrementing write-data port;
- drain the RAM through an auto-incrementing read-data port;
- arm a stop that ends capture a programmed number of words after a trigger;
- request a manual flush, which pads the write pointer with zero words up to the next four-word frame boundary.

The sequencer is a four-state machine:
- `ST_OFF`: capture disabled. This is the reset state.
- `ST_RUN`: accepting trace words.
- `ST_PAD`: flush in progress, writing zero words.
- `ST_HALT`: capture still enabled but stopped, either after the trigger count ran out or after a flush that was set to stop.

Transitions:
- `ST_OFF` goes to `ST_RUN` when the enable bit is 1.
- Any state goes to `ST_PAD` on a flush request.
- `ST_RUN` goes to `ST_HALT` when the trigger countdown is exhausted.
- `ST_RUN` and `ST_HALT` go to `ST_OFF` when the enable bit is 0.
- `ST_PAD` leaves once the write pointer is frame aligned. It goes to `ST_OFF` if the enable bit is 0, to `ST_HALT` if stop-after-flush is set, and to `ST_RUN` otherwise.

Register bus reads are combinational in the cycle the bus is enabled. Any side effect of an access (a pointer step, a load, a flush request) takes effect at the following clock edge. The RAM depth is a parameter and must be a power of two.

Top module: `trace_ring_sink`

## Requirements
- R1: After reset the control register reads 0 and both pointers read 0. The status register (0x00C) reads 0, `tr_ready` is low, and the flush-status register (0x300) reads 2: bit 1 (stopped) is 1 and bit 0 (flush busy) is 0.
- R2: Offset 0x004 reads the RAM depth. The write-data offset 0x024 and any unmapped offset read 0.
- R3: With control bit 0 set and the block in `ST_RUN`, `tr_ready` is high. Each word taken with `tr_valid` and `tr_ready` both high is stored at the write pointer (0x018), and the pointer then advances. `tr_ready` drops in the cycle after a write that clears control bit 0.
- R4: In `ST_OFF`, a write to 0x024 stores the word at the write pointer and advances it, and a write to 0x018 loads the pointer. In any other state both writes are ignored.
- R5: A read of 0x010 returns the word at the read pointer (0x014), and the pointer then advances. Writing 0x014 loads the read pointer.
- R6: Both pointers wrap modulo the depth. Status bit 0 becomes 1 when the write pointer wraps to 0. It stays 1 until the write pointer is written.
- R7: With flush-control bit 13 set, the word taken with `tr_trigger` high arms the stop. The trigger counter (0x01C) then decrements on each further word taken. Once it reads 0, `tr_ready` is low and the block enters `ST_HALT`.
- R8: With flush-control bit 13 clear, `tr_trigger` has no effect and capture continues.
- R9: Writing flush-control with bit 6 set starts a flush. Zero words are written until the write pointer is a multiple of 4. Bit 6 reads 1 and `tr_ready` is low until the flush completes.
- R10: When a flush completes with flush-control bit 12 set and capture enabled, the block halts. With bit 12 clear it resumes capture.
- R11: Flush-status bit 1 is 1 in `ST_OFF` and `ST_HALT` and 0 otherwise. Bit 0 is 1 only while a flush is in progress.
- R12: Flush-control bits 0, 12 and 13 read back as written. All other bits read 0, apart from bit 6 during a flush.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_en | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while `bus_en` is high and `bus_we` is low |
| tr_valid | input | 1 | Trace word present |
| tr_data | input | 32 | Trace word |
| tr_trigger | input | 1 | Marks the current trace word as the trigger |
| tr_ready | output | 1 | Sink accepts a word this cycle |

## Verification
The assertions rely on three properties of the register bus:
- at most one access per cycle;
- inputs held steady around each clock edge;
- no write to the trigger counter in the same cycle as the decrement they check.

The bench meets these by driving the bus and the trace inputs only on falling edges, issuing a single access per step, and loading the counter only while no word is being accepted. Trace words are offered whether or not `tr_ready` is high. The ready-gating logic is therefore what the single-writer property depends on.

// File: rtl/trs_pkg.sv
package trs_pkg;

    localparam int ADDR_W = 12;

    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_RUN  = 2'd1,
        ST_PAD  = 2'd2,
        ST_HALT = 2'd3
    } trs_state_e;

    // register offsets (software decodes these)
    localparam logic [ADDR_W-1:0] OFS_DEPTH = 12'h004;
    localparam logic [ADDR_W-1:0] OFS_STAT  = 12'h00C;
    localparam logic [ADDR_W-1:0] OFS_RDAT  = 12'h010;
    localparam logic [ADDR_W-1:0] OFS_RPTR  = 12'h014;
    localparam logic [ADDR_W-1:0] OFS_WPTR  = 12'h018;
    localparam logic [ADDR_W-1:0] OFS_TCNT  = 12'h01C;
    localparam logic [ADDR_W-1:0] OFS_CTRL  = 12'h020;
    localparam logic [ADDR_W-1:0] OFS_WDAT  = 12'h024;
    localparam logic [ADDR_W-1:0] OFS_FSTAT = 12'h300;
    localparam logic [ADDR_W-1:0] OFS_FCTL  = 12'h304;

    // flush-control bit positions
    localparam int FB_FMT_EN  = 0;
    localparam int FB_FLUSH   = 6;
    localparam int FB_STOP_FL = 12;
    localparam int FB_STOP_TR = 13;

    localparam int FRAME_W = 2;  // log2 of words per frame

endpackage

// File: rtl/trs_ring.sv
module trs_ring #(
    parameter int DEPTH = 64,
    parameter int DW    = 32,
    localparam int PW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cap_we,
    input  logic [DW-1:0] cap_data,
    input  logic          pad_we,
    input  logic          dat_we,
    input  logic [DW-1:0] dat_in,
    input  logic          wp_load,
    input  logic [PW-1:0] wp_val,
    input  logic          rp_load,
    input  logic [PW-1:0] rp_val,
    input  logic          rp_adv,
    output logic [PW-1:0] wp,
    output logic [PW-1:0] rp,
    output logic          full,
    output logic [DW-1:0] rd_word
);

    logic [DW-1:0] mem [DEPTH];
    logic          wr_any;
    logic [DW-1:0] wr_word;

    always_comb begin
        wr_any  = cap_we | pad_we | dat_we;
        wr_word = '0;
        if (cap_we)      wr_word = cap_data;
        else if (dat_we) wr_word = dat_in;
    end

    always_ff @(posedge clk) begin
        if (wr_any) mem[wp] <= wr_word;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp   <= '0;
            full <= 1'b0;
        end else if (wp_load) begin
            wp   <= wp_val;
            full <= 1'b0;
        end else if (wr_any) begin
            wp <= wp + PW'(1);
            if (wp == PW'(DEPTH - 1)) full <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)      rp <= '0;
        else if (rp_load) rp <= rp_val;
        else if (rp_adv)  rp <= rp + PW'(1);
    end

    assign rd_word = mem[rp];

    assert_wp_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_any && !wp_load) |=> (wp == $past(wp) + PW'(1)));

    assert_full_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(full) |-> $past(wp_load));

    assert_rp_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rp_adv && !rp_load) |=> (rp == $past(rp) + PW'(1)));

endmodule

// File: rtl/trs_ctrl.sv
module trs_ctrl
    import trs_pkg::*;
#(
    parameter int CW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          capt_en,
    input  logic          stop_trig,
    input  logic          stop_flush,
    input  logic          flush_req,
    input  logic          tr_valid,
    input  logic          tr_trigger,
    input  logic          wp_aligned,
    input  logic          cnt_wr,
    input  logic [CW-1:0] cnt_wdata,
    output trs_state_e    state,
    output logic          tr_ready,
    output logic          beat,
    output logic          pad_we,
    output logic          stopped,
    output logic [CW-1:0] trg_cnt
);

    trs_state_e nxt;
    logic       triggered;
    logic       cnt_zero;

    assign cnt_zero = (trg_cnt == '0);

    // next-state
    always_comb begin
        nxt = state;
        unique case (state)
            ST_OFF: begin
                if (flush_req)    nxt = ST_PAD;
                else if (capt_en) nxt = ST_RUN;
            end
            ST_RUN: begin
                if (flush_req)                  nxt = ST_PAD;
                else if (!capt_en)              nxt = ST_OFF;
                else if (triggered && cnt_zero) nxt = ST_HALT;
            end
            ST_HALT: begin
                if (flush_req)     nxt = ST_PAD;
                else if (!capt_en) nxt = ST_OFF;
            end
            ST_PAD: begin
                if (wp_aligned) begin
                    if (!capt_en)       nxt = ST_OFF;
                    else if (stop_flush) nxt = ST_HALT;
                    else                nxt = ST_RUN;
                end
            end
            default: nxt = ST_OFF;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_OFF;
        else        state <= nxt;
    end

    // outputs
    always_comb begin
        tr_ready = (state == ST_RUN) && capt_en && !(triggered && cnt_zero);
        beat     = tr_valid && tr_ready;
        pad_we   = (state == ST_PAD) && !wp_aligned;
        stopped  = (state == ST_OFF) || (state == ST_HALT);
    end

    // trigger arming and post-trigger countdown
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            triggered <= 1'b0;
            trg_cnt   <= '0;
        end else begin
            if (state == ST_OFF)
                triggered <= 1'b0;
            else if (beat && tr_trigger && stop_trig && !triggered)
                triggered <= 1'b1;

            if (cnt_wr)
                trg_cnt <= cnt_wdata;
            else if (beat && triggered && !cnt_zero)
                trg_cnt <= trg_cnt - CW'(1);
        end
    end

    assert_pad_exit_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PAD && wp_aligned) |=> (state != ST_PAD));

    assert_halt_count_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && triggered && cnt_zero && capt_en && !flush_req)
        |=> (state == ST_HALT));

    assert_cnt_down_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (beat && triggered && !cnt_zero && !cnt_wr) |=> (trg_cnt == $past(trg_cnt) - CW'(1)));

    assert_pad_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state == ST_PAD) |-> !tr_ready);

endmodule

// File: rtl/trs_regs.sv
module trs_regs
    import trs_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int DW    = 32,
    parameter int CW    = 32,
    localparam int PW   = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_en,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata,
    input  trs_state_e        state,
    input  logic              stopped,
    input  logic [PW-1:0]     wp,
    input  logic [PW-1:0]     rp,
    input  logic              full,
    input  logic [DW-1:0]     rd_word,
    input  logic [CW-1:0]     trg_cnt,
    output logic              capt_en,
    output logic              stop_trig,
    output logic              stop_flush,
    output logic              flush_req,
    output logic              dat_we,
    output logic              wp_load,
    output logic              rp_load,
    output logic              rp_adv,
    output logic              cnt_wr
);

    logic wr_op, rd_op, fmt_en, busy;

    assign wr_op = bus_en && bus_we;
    assign rd_op = bus_en && !bus_we;
    assign busy  = (state == ST_PAD);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            capt_en    <= 1'b0;
            fmt_en     <= 1'b0;
            stop_flush <= 1'b0;
            stop_trig  <= 1'b0;
        end else if (wr_op) begin
            if (bus_addr == OFS_CTRL) capt_en <= bus_wdata[0];
            if (bus_addr == OFS_FCTL) begin
                fmt_en     <= bus_wdata[FB_FMT_EN];
                stop_flush <= bus_wdata[FB_STOP_FL];
                stop_trig  <= bus_wdata[FB_STOP_TR];
            end
        end
    end

    always_comb begin
        flush_req = wr_op && (bus_addr == OFS_FCTL) && bus_wdata[FB_FLUSH] && !busy;
        dat_we    = wr_op && (bus_addr == OFS_WDAT) && (state == ST_OFF);
        wp_load   = wr_op && (bus_addr == OFS_WPTR) && (state == ST_OFF);
        rp_load   = wr_op && (bus_addr == OFS_RPTR);
        rp_adv    = rd_op && (bus_addr == OFS_RDAT);
        cnt_wr    = wr_op && (bus_addr == OFS_TCNT);
    end

    always_comb begin
        bus_rdata = '0;
        if (rd_op) begin
            case (bus_addr)
                OFS_DEPTH: bus_rdata = DW'(DEPTH);
                OFS_STAT:  bus_rdata = DW'(full);
                OFS_RDAT:  bus_rdata = rd_word;
                OFS_RPTR:  bus_rdata = DW'(rp);
                OFS_WPTR:  bus_rdata = DW'(wp);
                OFS_TCNT:  bus_rdata = DW'(trg_cnt);
                OFS_CTRL:  bus_rdata = DW'(capt_en);
                OFS_FSTAT: bus_rdata = DW'({stopped, busy});
                OFS_FCTL: begin
                    bus_rdata[FB_FMT_EN]  = fmt_en;
                    bus_rdata[FB_FLUSH]   = busy;
                    bus_rdata[FB_STOP_FL] = stop_flush;
                    bus_rdata[FB_STOP_TR] = stop_trig;
                end
                default:   bus_rdata = '0;
            endcase
        end
    end

    assert_bus_side_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_we || wp_load) |-> (state == ST_OFF));

endmodule

// File: rtl/trace_ring_sink.sv
module trace_ring_sink
    import trs_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int DW    = 32,
    parameter int CW    = 32,
    localparam int PW   = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_en,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata,
    input  logic              tr_valid,
    input  logic [DW-1:0]     tr_data,
    input  logic              tr_trigger,
    output logic              tr_ready
);

    trs_state_e    state;
    logic          stopped, beat, pad_we;
    logic          capt_en, stop_trig, stop_flush, flush_req;
    logic          dat_we, wp_load, rp_load, rp_adv, cnt_wr;
    logic [PW-1:0] wp, rp;
    logic          full;
    logic [DW-1:0] rd_word;
    logic [CW-1:0] trg_cnt;
    logic          wp_aligned;

    assign wp_aligned = (wp[FRAME_W-1:0] == '0);

    trs_regs #(.DEPTH(DEPTH), .DW(DW), .CW(CW)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .state(state), .stopped(stopped), .wp(wp), .rp(rp), .full(full),
        .rd_word(rd_word), .trg_cnt(trg_cnt),
        .capt_en(capt_en), .stop_trig(stop_trig), .stop_flush(stop_flush),
        .flush_req(flush_req), .dat_we(dat_we), .wp_load(wp_load),
        .rp_load(rp_load), .rp_adv(rp_adv), .cnt_wr(cnt_wr)
    );

    trs_ctrl #(.CW(CW)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .capt_en(capt_en), .stop_trig(stop_trig), .stop_flush(stop_flush),
        .flush_req(flush_req), .tr_valid(tr_valid), .tr_trigger(tr_trigger),
        .wp_aligned(wp_aligned), .cnt_wr(cnt_wr), .cnt_wdata(bus_wdata[CW-1:0]),
        .state(state), .tr_ready(tr_ready), .beat(beat), .pad_we(pad_we),
        .stopped(stopped), .trg_cnt(trg_cnt)
    );

    trs_ring #(.DEPTH(DEPTH), .DW(DW)) u_ring (
        .clk(clk), .rst_n(rst_n),
        .cap_we(beat), .cap_data(tr_data), .pad_we(pad_we),
        .dat_we(dat_we), .dat_in(bus_wdata),
        .wp_load(wp_load), .wp_val(bus_wdata[PW-1:0]),
        .rp_load(rp_load), .rp_val(bus_wdata[PW-1:0]), .rp_adv(rp_adv),
        .wp(wp), .rp(rp), .full(full), .rd_word(rd_word)
    );

    assert_one_writer_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({beat, pad_we, dat_we}) <= 1);

    assert_flush_aligns_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PAD && !wp_aligned) |=> (wp == $past(wp) + PW'(1)));

endmodule

// File: tb/tb_trace_ring_sink.sv
module tb_trace_ring_sink;
    import trs_pkg::*;

    localparam int DEPTH = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_en = 1'b0, bus_we = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        tr_valid = 1'b0, tr_trigger = 1'b0;
    logic [31:0] tr_data = '0;
    logic        tr_ready;

    always #5 clk = ~clk;

    trace_ring_sink #(.DEPTH(DEPTH)) dut (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tr_valid(tr_valid), .tr_data(tr_data), .tr_trigger(tr_trigger),
        .tr_ready(tr_ready)
    );

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    // behavioural reference: mode 0 off, 1 run, 2 pad, 3 halt
    int          m_mode, m_wp, m_rp;
    bit          m_full, m_ctrl, m_trig, m_f0, m_f12, m_f13;
    bit [31:0]   m_cnt;
    bit [31:0]   m_ram [DEPTH];

    function automatic bit m_ready();
        return (m_mode == 1) && m_ctrl && !(m_trig && m_cnt == 0);
    endfunction

    function automatic bit [31:0] m_read(input logic [11:0] a);
        case (a)
            12'h004: return DEPTH;
            12'h00C: return {31'b0, m_full};
            12'h010: return m_ram[m_rp];
            12'h014: return m_rp;
            12'h018: return m_wp;
            12'h01C: return m_cnt;
            12'h020: return {31'b0, m_ctrl};
            12'h300: return {30'b0, (m_mode == 0 || m_mode == 3), (m_mode == 2)};
            12'h304: return (32'(m_f13) << 13) | (32'(m_f12) << 12) |
                            (32'(m_mode == 2) << 6) | 32'(m_f0);
            default: return 0;
        endcase
    endfunction

    task automatic m_put(input bit [31:0] v);
        m_ram[m_wp] = v;
        m_wp = (m_wp + 1) % DEPTH;
        if (m_wp == 0) m_full = 1;
    endtask

    task automatic check(input string tag, input bit [31:0] act, input bit [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic step(input bit be, input bit bw, input logic [11:0] a,
                        input logic [31:0] wd, input bit tv, input logic [31:0] td,
                        input bit tt, input string tag);
        int  pm;
        bit  pc, pt, p12, p13, acc, al, fr, wr;
        bit [31:0] pcnt;
        @(negedge clk);
        bus_en = be; bus_we = bw; bus_addr = a; bus_wdata = wd;
        tr_valid = tv; tr_data = td; tr_trigger = tt;
        #2;
        check("R3 ready", 32'(tr_ready), 32'(m_ready()));
        if (be && !bw) check(tag, bus_rdata, m_read(a));
        pm = m_mode; pc = m_ctrl; pt = m_trig; pcnt = m_cnt; p12 = m_f12; p13 = m_f13;
        acc = tv && m_ready();
        al  = (m_wp % 4) == 0;
        wr  = be && bw;
        fr  = wr && a == 12'h304 && wd[6] && pm != 2;
        if (acc) m_put(td);
        if (pm == 2 && !al) m_put(0);
        if (pm == 0 && wr && a == 12'h024) m_put(wd);
        if (pm == 0 && wr && a == 12'h018) begin m_wp = wd % DEPTH; m_full = 0; end
        if (wr && a == 12'h014) m_rp = wd % DEPTH;
        else if (be && !bw && a == 12'h010) m_rp = (m_rp + 1) % DEPTH;
        if (pm == 0) m_trig = 0;
        else if (acc && tt && p13 && !pt) m_trig = 1;
        if (wr && a == 12'h01C) m_cnt = wd;
        else if (acc && pt && pcnt != 0) m_cnt = pcnt - 1;
        if (wr && a == 12'h020) m_ctrl = wd[0];
        if (wr && a == 12'h304) begin m_f0 = wd[0]; m_f12 = wd[12]; m_f13 = wd[13]; end
        case (pm)
            0: m_mode = fr ? 2 : (pc ? 1 : 0);
            1: m_mode = fr ? 2 : (!pc ? 0 : ((pt && pcnt == 0) ? 3 : 1));
            3: m_mode = fr ? 2 : (!pc ? 0 : 3);
            default: m_mode = al ? (!pc ? 0 : (p12 ? 3 : 1)) : 2;
        endcase
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        step(1, 1, a, d, 0, 0, 0, "");
    endtask
    task automatic rd(input logic [11:0] a, input string tag);
        step(1, 0, a, 0, 0, 0, 0, tag);
    endtask
    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, 0, "");
    endtask
    task automatic push(input logic [31:0] d, input bit t);
        step(0, 0, 0, 0, 1, d, t, "");
    endtask

    initial begin
        m_mode = 0; m_wp = 0; m_rp = 0; m_full = 0; m_ctrl = 0; m_trig = 0;
        m_f0 = 0; m_f12 = 0; m_f13 = 0; m_cnt = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset values
        rd(12'h020, "R1 ctrl"); rd(12'h00C, "R1 status"); rd(12'h018, "R1 wptr");
        rd(12'h014, "R1 rptr"); rd(12'h300, "R1 fstat"); rd(12'h304, "R1 fctl");
        // R2 map
        rd(12'h004, "R2 depth"); rd(12'h100, "R2 unmapped"); rd(12'h024, "R2 wdata");
        // R4 R6 fill RAM through the write-data port
        wr(12'h018, 0);
        for (int i = 0; i < DEPTH; i++) wr(12'h024, 32'hA500_0000 + i);
        rd(12'h00C, "R6 full set"); rd(12'h018, "R6 wrap");
        wr(12'h018, 3); rd(12'h00C, "R6 full clear"); rd(12'h018, "R4 load");
        // R5 drain
        wr(12'h014, 0);
        for (int i = 0; i < DEPTH; i++) rd(12'h010, "R5 data");
        rd(12'h014, "R5 rptr wrap");
        wr(12'h014, 5); rd(12'h010, "R5 reload");
        // R3 capture with gaps
        wr(12'h018, 0); wr(12'h020, 1); idle(1);
        for (int i = 0; i < 10; i++) step(0, 0, 0, 0, (i % 3) != 1, 32'hC0DE_0000 + i, 0, "");
        wr(12'h018, 9); rd(12'h018, "R4 wptr ignored");
        wr(12'h024, 32'hDEAD); rd(12'h018, "R4 wdata ignored");
        // R9 manual flush, resume (R10)
        wr(12'h304, 32'h41); rd(12'h304, "R9 busy"); rd(12'h300, "R11 busy");
        idle(4); rd(12'h304, "R9 done"); rd(12'h018, "R9 aligned"); rd(12'h300, "R10 resumed");
        for (int i = 0; i < 3; i++) push(32'hF100_0000 + i, 0);
        // R7 stop after trigger
        wr(12'h01C, 3); wr(12'h304, 32'h2001); rd(12'h304, "R12 readback");
        push(32'h7000_0001, 0); push(32'h7000_0002, 0); push(32'h7000_0003, 1);
        rd(12'h01C, "R7 count");
        for (int i = 0; i < 8; i++) push(32'h7100_0000 + i, 0);
        rd(12'h01C, "R7 zero"); rd(12'h300, "R7 halted"); rd(12'h018, "R7 wptr");
        rd(12'h00C, "R6 capture wrap");
        // R8 trigger ignored without stop bit
        wr(12'h020, 0); idle(1); rd(12'h300, "R11 off"); wr(12'h304, 1); wr(12'h01C, 0);
        wr(12'h020, 1); idle(1);
        push(32'h8000_0000, 1);
        for (int i = 0; i < 6; i++) push(32'h8100_0000 + i, 0);
        rd(12'h018, "R8 wptr"); rd(12'h300, "R8 running");
        // R10 flush then halt
        wr(12'h304, 32'h1041); idle(5); rd(12'h300, "R10 halted");
        push(32'hBAD0, 0); push(32'hBAD1, 0); rd(12'h018, "R10 wptr held");
        wr(12'h304, 32'h0041); idle(2); rd(12'h300, "R10 resume");
        push(32'h9000_0000, 0); push(32'h9000_0001, 0);
        // R12 field masking
        wr(12'h304, 32'hFFFF_CFBE); rd(12'h304, "R12 mask");
        // dump
        wr(12'h020, 0); idle(2); rd(12'h300, "R11 stopped");
        wr(12'h014, 0);
        for (int i = 0; i < DEPTH; i++) rd(12'h010, "R5 dump");
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #2_000_000;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule